// File: doc/BRIEF.md
# Transaction-Complete Endpoint Work Queue

This block keeps a first-come, first-served list of endpoints that have finished a successful IN or OUT transaction and now need attention from software. Each time the transfer engine reports a completion, the block stores that endpoint's 16-bit configuration-table address in a ring that lives in shared byte-wide SRAM, directly beneath a programmable base address, and advances its write pointer.

Software finds the head entry from the read pointer and removes it by reading the read-pointer register; that read is the pop. Both pointers are 5-bit values in one's-complement form, so they are the low bits of a negative offset from the base: entry index k sits at base − 2·(k+1). The ring holds 2·(sel+1) entries, where sel is a 4-bit depth selection, and it is only active while enabled. A flag tells software that work is waiting or that the ring is full.

Top module: `tc_work_queue`

## Requirements
- R1: After reset, and in any cycle while `enable` is low, both pointers read 5'h1F, `tc_flag`, `full_o` and `mem_we` are 0, `level_o` is 0 and `done_ready` is 1.
- R2: An accepted completion is written as two byte writes on consecutive cycles, starting the cycle after acceptance. The first write puts the low byte at base + 2·{ones,wptr} (16-bit wrap, with wptr the value before the push, which equals base − 2·(k+1)). The second puts the high byte at that address + 1.
- R3: Each accepted completion moves the write index k (stored pointer = ~k) from k to k+1, and from 2·(sel+1)−1 back to 0, so the stored pointer returns to 5'h1F.
- R4: A read strobe on the read-pointer register while the ring holds entries advances the read index by the same rule as R3. A strobe on an empty ring leaves it unchanged.
- R5: A read strobe on the write-pointer register changes neither pointer, the flag nor the level.
- R6: `tc_flag` is 1 exactly when the two pointers differ or the ring is full.
- R7: `full_o` is set by a push that makes the pointers equal and is cleared by any pop. A completion offered while full is dropped: no write, and no pointer moves.
- R8: `level_o` equals the number of stored entries, from 0 up to 2·(sel+1).
- R9: `done_ready` is low during the two write cycles, and a completion offered then is dropped.
- R10: Dropping `enable` returns the pointers, full bit and writer to their reset state. Completions offered while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Queue active; low clears it |
| depth_sel | input | 4 | Ring holds 2·(depth_sel+1) entries |
| base_addr | input | 16 | SRAM byte address just above the ring |
| done_valid | input | 1 | Successful transaction completion event |
| done_addr | input | 16 | Configuration-table address of that endpoint |
| done_ready | output | 1 | Writer idle; an event can be accepted |
| rptr_read | input | 1 | Software read of the read-pointer register (pops) |
| wptr_read | input | 1 | Software read of the write-pointer register (no effect) |
| rptr_o | output | 5 | Read pointer, one's-complement form |
| wptr_o | output | 5 | Write pointer, one's-complement form |
| mem_we | output | 1 | SRAM byte write strobe |
| mem_addr | output | 16 | SRAM byte address |
| mem_wdata | output | 8 | SRAM byte data |
| tc_flag | output | 1 | Work pending or ring full |
| full_o | output | 1 | Ring full |
| level_o | output | 6 | Number of stored entries |

## Verification
The bench fills the smallest ring (two entries) so the pointers meet again. A design without the full bit would report it empty and drop the flag. Pushes offered while full, or while the writer is busy, must leave no write and no pointer change; a design that accepted them would overwrite the oldest unread entry. The largest ring is driven past its natural 5-bit wrap, and the middle sizes past their non-power-of-two wrap, where an off-by-one index would leave a gap in SRAM and corrupt the level. A base near zero makes addresses wrap below 0x0000, pops on an empty ring must not move the read pointer, and write-pointer reads must be inert.

// File: rtl/tcq_pkg.sv
package tcq_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_phase_e;
endpackage

// File: rtl/tcq_ring_ptr.sv
module tcq_ring_ptr #(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [PTR_W:0]   depth,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] ptr_step_o
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ring_t;

    ring_t            st_d, st_q;
    logic [PTR_W-1:0] idx_now;
    logic [PTR_W-1:0] idx_inc;
    logic             at_end;

    always_comb begin
        idx_now    = ~st_q.ptr;
        at_end     = ({1'b0, idx_now} == (depth - 1'b1));
        idx_inc    = at_end ? '0 : idx_now + 1'b1;
        ptr_step_o = ~idx_inc;
        st_d       = st_q;
        if (clr) begin
            st_d.ptr = '1;
        end else if (step) begin
            st_d.ptr = ptr_step_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;

    // R3: the last index wraps to the top of the ring
    a_r3_wrap_to_top: assert property (@(posedge clk) disable iff (!rst_n)
        step && !clr && at_end |=> ptr_o == '1);
    // R3: an ordinary step lowers the stored value by one
    a_r3_single_dec: assert property (@(posedge clk) disable iff (!rst_n)
        step && !clr && !at_end |=> ptr_o == $past(ptr_o) - 1'b1);
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step && !clr |=> $stable(ptr_o));
endmodule

// File: rtl/tcq_byte_writer.sv
module tcq_byte_writer
    import tcq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               start,
    input  logic [ADDR_W-1:0]  lo_addr,
    input  logic [ENTRY_W-1:0] entry,
    output logic               we_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [BYTE_W-1:0]  wdata_o,
    output logic               idle_o
);
    localparam int NBYTES = ENTRY_W / BYTE_W;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        wr_phase_e          phase;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [ENTRY_W-1:0] data;
    } wr_t;

    wr_t  st_d, st_q;
    logic last;

    always_comb begin
        last = (st_q.cnt == CNT_W'(NBYTES - 1));
        st_d = st_q;
        if (clr) begin
            st_d.phase = WR_IDLE;
            st_d.cnt   = '0;
        end else if (st_q.phase == WR_BUSY) begin
            st_d.phase = last ? WR_IDLE : WR_BUSY;
            st_d.cnt   = last ? '0 : st_q.cnt + 1'b1;
            st_d.addr  = st_q.addr + 1'b1;
            st_d.data  = st_q.data >> BYTE_W;
        end else if (start) begin
            st_d.phase = WR_BUSY;
            st_d.cnt   = '0;
            st_d.addr  = lo_addr;
            st_d.data  = entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: WR_IDLE, cnt: '0, addr: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o    = (st_q.phase == WR_BUSY);
    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.data[BYTE_W-1:0];
    assign idle_o  = (st_q.phase == WR_IDLE);

    // R2: bytes of one entry go to climbing addresses on back-to-back cycles
    a_r2_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
        we_o && !last && !clr |=> we_o && addr_o == $past(addr_o) + 1'b1);
    // R2: the strobe drops after the last byte
    a_r2_stops_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        we_o && last && !clr |=> !we_o);
    // R9: a start offered mid-write does not reload the address
    a_r9_busy_keeps_course: assert property (@(posedge clk) disable iff (!rst_n)
        we_o && !last && !clr && start |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/tc_work_queue.sv
module tc_work_queue
    import tcq_pkg::*;
#(
    parameter int SEL_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [SEL_W-1:0]   depth_sel,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               done_valid,
    input  logic [ENTRY_W-1:0] done_addr,
    output logic               done_ready,
    input  logic               rptr_read,
    input  logic               wptr_read,
    output logic [SEL_W:0]     rptr_o,
    output logic [SEL_W:0]     wptr_o,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]  mem_wdata,
    output logic               tc_flag,
    output logic               full_o,
    output logic [SEL_W+1:0]   level_o
);
    localparam int PTR_W = SEL_W + 1;
    localparam int LVL_W = PTR_W + 1;
    localparam int EXT_W = ADDR_W - PTR_W;

    typedef struct packed {
        logic full;
    } ctl_t;

    ctl_t              st_d, st_q;
    logic [LVL_W-1:0]  depth;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_next, rd_next;
    logic [PTR_W-1:0]  wr_idx, rd_idx;
    logic [LVL_W-1:0]  diff;
    logic [ADDR_W-1:0] neg_off;
    logic [ADDR_W-1:0] lo_addr;
    logic              push, pop, clr, wr_idle;

    assign depth = (LVL_W'(depth_sel) + 1'b1) << 1;
    assign clr   = !enable;

    tcq_ring_ptr #(.PTR_W(PTR_W)) u_wr_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .step      (push),
        .depth     (depth),
        .ptr_o     (wr_ptr),
        .ptr_step_o(wr_next)
    );

    tcq_ring_ptr #(.PTR_W(PTR_W)) u_rd_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .step      (pop),
        .depth     (depth),
        .ptr_o     (rd_ptr),
        .ptr_step_o(rd_next)
    );

    always_comb begin
        push    = enable && done_valid && wr_idle && !st_q.full;
        pop     = enable && rptr_read && ((rd_ptr != wr_ptr) || st_q.full);
        neg_off = {{EXT_W{1'b1}}, wr_ptr};
        lo_addr = base_addr + (neg_off << 1);
        st_d    = st_q;
        if (clr || pop) begin
            st_d.full = 1'b0;
        end else if (push && (wr_next == rd_ptr)) begin
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.full <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    tcq_byte_writer #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_writer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .start  (push),
        .lo_addr(lo_addr),
        .entry  (done_addr),
        .we_o   (mem_we),
        .addr_o (mem_addr),
        .wdata_o(mem_wdata),
        .idle_o (wr_idle)
    );

    always_comb begin
        wr_idx = ~wr_ptr;
        rd_idx = ~rd_ptr;
        diff   = {1'b0, wr_idx} - {1'b0, rd_idx};
        if (wr_idx < rd_idx) begin
            diff = diff + depth;
        end
        level_o = st_q.full ? depth : diff;
    end

    assign done_ready = wr_idle;
    assign rptr_o     = rd_ptr;
    assign wptr_o     = wr_ptr;
    assign tc_flag    = (wr_ptr != rd_ptr) || st_q.full;
    assign full_o     = st_q.full;

    // R7: full only when the pointers have met
    a_r7_full_means_equal: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> wptr_o == rptr_o);
    // R7: an event offered while full leaves the write pointer alone
    a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        enable && full_o && done_valid |=> $stable(wptr_o));
    // R4: a read of the empty ring does not move the read pointer
    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        enable && rptr_read && !tc_flag |=> $stable(rptr_o));
    // R4: a pop lands on the stepped value
    a_r4_pop_lands: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> rptr_o == $past(rd_next));
    // R5: write-pointer reads alone change nothing
    a_r5_wptr_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
        enable && wptr_read && !push && !pop |=> $stable(wptr_o) && $stable(rptr_o));
    // R6/R8: a cleared flag means nothing is stored
    a_r6_flag_level: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_flag |-> level_o == '0);
    // R10: one disabled cycle empties the ring
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> wptr_o == '1 && rptr_o == '1 && !full_o && !mem_we);
endmodule

// File: tb/tc_work_queue_tb_top.sv
module tc_work_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  depth_sel = 4'd0;
    logic [15:0] base_addr = 16'h0400;
    logic        done_valid = 1'b0;
    logic [15:0] done_addr = 16'h0;
    logic        done_ready;
    logic        rptr_read = 1'b0;
    logic        wptr_read = 1'b0;
    logic [4:0]  rptr_o, wptr_o;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        tc_flag, full_o;
    logic [5:0]  level_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int kw = 0, kr = 0, mfull = 0, busy = 0, depth_n = 2;
    int la = 0;
    logic [15:0] ld = 16'h0;

    always #2 clk = ~clk;

    tc_work_queue dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
        .base_addr(base_addr), .done_valid(done_valid), .done_addr(done_addr),
        .done_ready(done_ready), .rptr_read(rptr_read), .wptr_read(wptr_read),
        .rptr_o(rptr_o), .wptr_o(wptr_o), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .tc_flag(tc_flag), .full_o(full_o), .level_o(level_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_ptr(input int k);
        return (~k) & 31;
    endfunction

    function automatic int exp_level();
        return mfull ? depth_n : (kw - kr + depth_n) % depth_n;
    endfunction

    task automatic compare_all();
        chk(wptr_o == 5'(exp_ptr(kw)), "R3 wptr", wptr_o, exp_ptr(kw));
        chk(rptr_o == 5'(exp_ptr(kr)), "R4 rptr", rptr_o, exp_ptr(kr));
        chk(tc_flag == ((kw != kr) || mfull), "R6 flag", tc_flag, (kw != kr) || mfull);
        chk(full_o == (mfull != 0), "R7 full", full_o, mfull);
        chk(level_o == 6'(exp_level()), "R8 level", level_o, exp_level());
        chk(done_ready == (busy == 0), "R9 ready", done_ready, busy == 0);
        chk(mem_we == (busy > 0), "R2 we", mem_we, busy > 0);
        if (busy == 2) begin
            chk(mem_addr == 16'(la), "R2 lo addr", mem_addr, la & 'hFFFF);
            chk(mem_wdata == ld[7:0], "R2 lo data", mem_wdata, ld[7:0]);
        end else if (busy == 1) begin
            chk(mem_addr == 16'(la + 1), "R2 hi addr", mem_addr, (la + 1) & 'hFFFF);
            chk(mem_wdata == ld[15:8], "R2 hi data", mem_wdata, ld[15:8]);
        end
    endtask

    // one cycle: drive at negedge, sample at the following negedge
    task automatic step(input bit v, input logic [15:0] a, input bit rr, input bit rw);
        bit acc, pp;
        done_valid = v; done_addr = a; rptr_read = rr; wptr_read = rw;
        acc = enable && v && busy == 0 && !mfull;
        pp  = enable && rr && (kr != kw || mfull);
        @(posedge clk);
        @(negedge clk);
        if (!enable) begin
            kw = 0; kr = 0; mfull = 0; busy = 0;
        end else begin
            if (busy > 0) busy--;
            if (acc) begin
                la = (int'(base_addr) - 2 * kw - 2) & 'hFFFF;
                ld = a;
                kw = (kw + 1) % depth_n;
                busy = 2;
            end
            if (pp) begin
                kr = (kr + 1) % depth_n;
                mfull = 0;
            end else if (acc && kw == kr) begin
                mfull = 1;
            end
        end
        done_valid = 0; rptr_read = 0; wptr_read = 0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 16'h0, 0, 0);
    endtask

    task automatic set_cfg(input logic [3:0] sel, input logic [15:0] base);
        idle(3);
        enable = 0;
        idle(1);
        depth_sel = sel; base_addr = base;
        depth_n = 2 * (int'(sel) + 1);
        enable = 1;
        idle(1);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(wptr_o == 5'h1F && rptr_o == 5'h1F, "R1 ptrs", {wptr_o, rptr_o}, 10'h3FF);
        chk(!tc_flag && !full_o && !mem_we && level_o == 0 && done_ready,
            "R1 outs", {tc_flag, full_o, mem_we, level_o == 0, done_ready}, 5'b00011);
        rst_n = 1;
        idle(2);

        // two-entry ring: fill, overfill, drain, read empty
        set_cfg(4'd0, 16'h0400);
        step(1, 16'hA1B2, 0, 0); idle(2);
        step(1, 16'hC3D4, 0, 0); idle(2);
        chk(full_o && tc_flag && wptr_o == rptr_o, "R7 full at meet", full_o, 1);
        step(1, 16'hDEAD, 0, 0);               // R7: dropped while full
        chk(!mem_we, "R7 no write when full", mem_we, 0);
        step(0, 16'h0, 0, 1);                  // R5: write-pointer read
        chk(wptr_o == 5'h1F && rptr_o == 5'h1F && level_o == 2, "R5 inert",
            {wptr_o, rptr_o, level_o}, {5'h1F, 5'h1F, 6'd2});
        step(0, 16'h0, 1, 0);
        step(0, 16'h0, 1, 0);
        chk(!tc_flag, "R4 drained", tc_flag, 0);
        step(0, 16'h0, 1, 0);                  // R4: empty read
        chk(rptr_o == 5'h1F, "R4 empty read", rptr_o, 5'h1F);

        // R9: back-to-back events, second falls in the write window
        step(1, 16'h1111, 0, 0);
        step(1, 16'h2222, 0, 0);
        step(1, 16'h3333, 0, 0);
        idle(1);
        chk(level_o == 1, "R9 busy drop", level_o, 1);

        // largest ring, base near zero, run well past the wrap
        set_cfg(4'd15, 16'h0010);
        for (int i = 0; i < 45; i++) begin
            step(1, 16'(i * 16'h0101 + 16'h0F0F), (i % 3) == 0, 0);
            idle(2);
        end

        // R10: disable with entries stored, then an event while disabled
        enable = 0;
        step(1, 16'h7777, 0, 0);
        chk(wptr_o == 5'h1F && rptr_o == 5'h1F && !full_o && !mem_we, "R10 cleared",
            {wptr_o, rptr_o}, 10'h3FF);
        step(1, 16'h7777, 0, 0);
        chk(!mem_we && level_o == 0, "R10 ignored", level_o, 0);
        enable = 1;
        idle(1);

        // random phase over several ring sizes and bases
        for (int c = 0; c < 8; c++) begin
            set_cfg(4'($urandom_range(0, 15)), 16'($urandom));
            for (int i = 0; i < 600; i++) begin
                step(($urandom % 3) == 0, 16'($urandom), ($urandom % 4) == 0,
                     ($urandom % 5) == 0);
            end
        end
        set_cfg(4'd2, 16'h8000);               // non-power-of-two wrap
        for (int i = 0; i < 30; i++) begin
            step(1, 16'(16'hBEEF ^ i), (i % 4) == 1, 0);
            idle(2);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule